// File: doc/BRIEF.md
# DMA Command Pointer-List Generator

This block turns one transfer request into the word stream that a DMA engine expects in its command queue. A request has a transfer kind, a source-side start address, a destination-side start address and a byte count. The generator cuts each of the two address ranges into segments, which it calls the first list and the last list. It sends a header word that holds both segment counts, then the first list, then the last list. When the final word is taken it reports the total word count, which the caller writes to the engine's doorbell.

The two lists can each use one of two segment formats. Local-memory segments take one word each and hold up to 8191 bytes. Bus-side segments hold up to 65535 bytes and are packed in groups: one length word with four 16-bit lanes, followed by one address word for each lane in use. The transfer kind picks the format of each list. An optional compatibility mode rejects requests whose segment counts exceed a legacy size rule. A rejected request emits no words.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. The output side is a valid/ready stream. Once `out_valid` is raised, it stays high and `out_data` does not change until a clock edge where `out_ready` is high. The consumer can hold `out_ready` low for any number of cycles without losing a word.

Top module: `dmacmd_gen`

## Requirements
- R1: A local-format list is cut into chunks of 8191 bytes, and the final chunk carries the remainder. Each local pointer word holds the chunk length in bits [12:0] and the chunk address in bits [52:13]. All other bits are zero.
- R2: A bus-format segment covers at most 65535 bytes. In a length word, lane k occupies bits [16k+15:16k]. Unused lanes are zero. A bus address word is the segment address zero-extended to 64 bits.
- R3: A bus-format list is sent as repeated groups. Each group is one length word followed by one address word for each lane in use (at most four). A list of n bus segments takes n + (n-1)/4 + 1 words, using integer division.
- R4: Within a list, each segment address equals the previous segment address plus the previous segment length, modulo 2^40. The first segment of each list starts at that list's request address.
- R5: `req_type` selects the list formats. 0 (internal) uses local/local. 1 (inbound) and 2 (outbound) use local/bus. 3 (external) uses bus/bus. The first list takes `req_first_addr` and the last list takes `req_last_addr`. Both lists use `req_size`.
- R6: The first word of every accepted, non-rejected request is the header. Bits [6:0] hold the first-list segment count, bits [13:7] hold the last-list segment count, and bits [15:14] hold the transfer kind. All higher bits are zero. The counts are segments, not words.
- R7: When `compat_en` is high at acceptance and either segment count exceeds 11, or the two counts together exceed 15, the block emits no word and pulses `err` for one cycle. It then returns to idle.
- R8: After the last word of a request is accepted, `done` is high for exactly one cycle. At that time `doorbell` equals the total number of words emitted, including the header.
- R9: A `req_size` of zero gives zero segments in both lists. Only the header is emitted, and the doorbell is 1.
- R10: After reset, `req_ready` is 1 and `out_valid`, `done` and `err` are 0. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_type | input | 2 | Transfer kind: 0 internal, 1 inbound, 2 outbound, 3 external |
| req_first_addr | input | 40 | Start address of the first list |
| req_last_addr | input | 40 | Start address of the last list |
| req_size | input | 19 | Transfer length in bytes |
| compat_en | input | 1 | Enables the legacy count limit, sampled with the request |
| out_valid | output | 1 | Command word offered |
| out_ready | input | 1 | Consumer takes the word on this edge |
| out_data | output | 64 | Command word |
| done | output | 1 | One-cycle pulse after the last word is taken |
| err | output | 1 | One-cycle pulse for a rejected request |
| doorbell | output | 9 | Total word count, valid while done is high |

## Verification
Directed requests sit at the chunk limits of each format. These are sizes of exactly 8191 and 8192 bytes, 65535 and 65536 bytes, and a bus size that needs six segments. Together they separate an off-by-one in the chunk cut from an error in group packing and lane placement. Each of the four transfer kinds is sent at least once, which shows whether the list formats are mapped to the right list and address. Compatibility requests sit just inside and just outside the single-count and sum limits, and the same oversized request is also sent with the mode off, so a wrong comparison or a rejection that leaks words shows up. Random requests mix kinds, sizes including zero, and addresses near the wrap, while `out_ready` is dropped at random, which exercises the hold rule and the address stepping under back-pressure.

// File: rtl/dmacmd_pkg.sv
package dmacmd_pkg;

  typedef enum logic [1:0] {
    XF_INTERNAL = 2'd0,
    XF_INBOUND  = 2'd1,
    XF_OUTBOUND = 2'd2,
    XF_EXTERNAL = 2'd3
  } xfer_e;

  typedef enum logic {
    SEG_LOCAL = 1'b0,
    SEG_BUS   = 1'b1
  } seg_fmt_e;

  // Segment limits of the two formats
  localparam int LOCAL_LIMIT   = 8191;
  localparam int BUS_LIMIT     = 65535;
  localparam int LOCAL_LEN_W   = 13;
  localparam int LANE_W        = 16;
  localparam int LANES         = 4;
  // Legacy count rule
  localparam int COMPAT_ONE_MAX = 11;
  localparam int COMPAT_SUM_MAX = 15;

  // Format of list 0 (first) or list 1 (last) for a transfer kind
  function automatic seg_fmt_e fmt_of(xfer_e kind, logic last_list);
    if (!last_list) return (kind == XF_EXTERNAL) ? SEG_BUS : SEG_LOCAL;
    else            return (kind == XF_INTERNAL) ? SEG_LOCAL : SEG_BUS;
  endfunction

endpackage

// File: rtl/dmacmd_seg_count.sv
// Counts the segments of one list ahead of emission, one segment per cycle.
module dmacmd_seg_count
  import dmacmd_pkg::*;
#(
  parameter int SIZE_W = 19,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  seg_fmt_e          fmt,
  input  logic [SIZE_W-1:0] size,
  output logic              busy,
  output logic [CNT_W-1:0]  count
);

  logic [SIZE_W-1:0] rem_q;
  logic [SIZE_W-1:0] limit;
  logic [SIZE_W-1:0] chunk;
  logic [CNT_W-1:0]  cnt_q;
  seg_fmt_e          fmt_q;

  always_comb begin
    limit = (fmt_q == SEG_BUS) ? SIZE_W'(BUS_LIMIT) : SIZE_W'(LOCAL_LIMIT);
    chunk = (rem_q > limit) ? limit : rem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
      fmt_q <= SEG_LOCAL;
    end else if (start) begin
      rem_q <= size;
      cnt_q <= '0;
      fmt_q <= fmt;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - chunk;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy  = (rem_q != '0);
  assign count = cnt_q;

  // The remaining length shrinks every busy cycle, so the pass terminates
  AST_COUNT_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> rem_q < $past(rem_q)); // R1

endmodule

// File: rtl/dmacmd_walker.sv
// Emits the pointer words of one list on a valid/ready stream.
module dmacmd_walker
  import dmacmd_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int SIZE_W = 19,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  seg_fmt_e          fmt,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] size,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data,
  output logic              fin
);

  typedef enum logic [1:0] {W_IDLE, W_LEN, W_PTR, W_FIN} wst_e;

  wst_e              st_q;
  seg_fmt_e          fmt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] rem_q;
  logic [1:0]        lane_q;
  logic [SIZE_W-1:0] limit;
  logic [SIZE_W-1:0] chunk;
  logic [DATA_W-1:0] len_word;
  logic              last_seg;

  always_comb begin
    limit    = (fmt_q == SEG_BUS) ? SIZE_W'(BUS_LIMIT) : SIZE_W'(LOCAL_LIMIT);
    chunk    = (rem_q > limit) ? limit : rem_q;
    last_seg = (rem_q == chunk);
  end

  // Group length word: lanes filled from the remaining length, unused lanes zero
  always_comb begin
    logic [SIZE_W-1:0] rr;
    logic [SIZE_W-1:0] ln;
    len_word = '0;
    rr       = rem_q;
    for (int k = 0; k < LANES; k++) begin
      ln = (rr > SIZE_W'(BUS_LIMIT)) ? SIZE_W'(BUS_LIMIT) : rr;
      len_word[k*LANE_W +: LANE_W] = ln[LANE_W-1:0];
      rr = rr - ln;
    end
  end

  always_comb begin
    o_data = '0;
    unique case (st_q)
      W_LEN: o_data = len_word;
      W_PTR: begin
        if (fmt_q == SEG_BUS) o_data = DATA_W'(addr_q);
        else o_data = DATA_W'({addr_q, chunk[LOCAL_LEN_W-1:0]});
      end
      default: o_data = '0;
    endcase
  end

  assign o_valid = (st_q == W_LEN) || (st_q == W_PTR);
  assign fin     = (st_q == W_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      fmt_q  <= SEG_LOCAL;
      addr_q <= '0;
      rem_q  <= '0;
      lane_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: begin
          if (start) begin
            fmt_q  <= fmt;
            addr_q <= base;
            rem_q  <= size;
            lane_q <= '0;
            if (size == '0)          st_q <= W_FIN;
            else if (fmt == SEG_BUS) st_q <= W_LEN;
            else                     st_q <= W_PTR;
          end
        end
        W_LEN: begin
          if (o_ready) begin
            lane_q <= '0;
            st_q   <= W_PTR;
          end
        end
        W_PTR: begin
          if (o_ready) begin
            addr_q <= addr_q + ADDR_W'(chunk);
            rem_q  <= rem_q - chunk;
            lane_q <= lane_q + 1'b1;
            if (last_seg)                                st_q <= W_FIN;
            else if (fmt_q == SEG_BUS && lane_q == 2'd3) st_q <= W_LEN;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data)); // R10

  AST_LOCAL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && st_q == W_PTR && fmt_q == SEG_LOCAL |-> o_data[LOCAL_LEN_W-1:0] != '0); // R1

  AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && st_q == W_LEN |-> o_data[LANE_W-1:0] != '0); // R3

  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin && !o_valid); // R8

endmodule

// File: rtl/dmacmd_gen.sv
// Request-to-command-stream generator: count pass, header, first list, last list.
module dmacmd_gen
  import dmacmd_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int SIZE_W = 19,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7,
  parameter int WCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_first_addr,
  input  logic [ADDR_W-1:0] req_last_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              compat_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done,
  output logic              err,
  output logic [WCNT_W-1:0] doorbell
);

  localparam int NLISTS = 2;
  localparam int TYPE_LO = 2 * CNT_W;

  typedef enum logic [2:0] {T_IDLE, T_COUNT, T_HDR, T_L0, T_L1, T_DONE, T_ERR} tst_e;

  tst_e              st_q;
  xfer_e             kind_q;
  logic              compat_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q [NLISTS];
  logic [WCNT_W-1:0] db_q;

  seg_fmt_e          cnt_fmt  [NLISTS];
  seg_fmt_e          walk_fmt [NLISTS];
  logic [CNT_W-1:0]  seg_cnt  [NLISTS];
  logic [DATA_W-1:0] w_data   [NLISTS];
  logic [NLISTS-1:0] c_busy;
  logic [NLISTS-1:0] w_valid;
  logic [NLISTS-1:0] w_ready;
  logic [NLISTS-1:0] w_start;
  logic [NLISTS-1:0] w_fin;

  logic              accept;
  logic              counted;
  logic              too_big;
  logic [CNT_W:0]    cnt_sum;
  logic [WCNT_W-1:0] words_total;
  logic [DATA_W-1:0] hdr_word;

  function automatic logic [WCNT_W-1:0] list_words(seg_fmt_e f, logic [CNT_W-1:0] n);
    logic [WCNT_W-1:0] nn;
    nn = WCNT_W'(n);
    if (f == SEG_LOCAL || n == '0) return nn;
    return nn + ((nn - 1'b1) >> 2) + 1'b1;
  endfunction

  assign accept  = (st_q == T_IDLE) && req_valid;
  assign counted = (st_q == T_COUNT) && (c_busy == '0);

  for (genvar g = 0; g < NLISTS; g++) begin : g_list
    assign cnt_fmt[g]  = fmt_of(xfer_e'(req_type), g[0]);
    assign walk_fmt[g] = fmt_of(kind_q, g[0]);

    dmacmd_seg_count #(
      .SIZE_W(SIZE_W),
      .CNT_W (CNT_W)
    ) u_count (
      .clk  (clk),
      .rst_n(rst_n),
      .start(accept),
      .fmt  (cnt_fmt[g]),
      .size (req_size),
      .busy (c_busy[g]),
      .count(seg_cnt[g])
    );

    dmacmd_walker #(
      .ADDR_W(ADDR_W),
      .SIZE_W(SIZE_W),
      .DATA_W(DATA_W)
    ) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (w_start[g]),
      .fmt    (walk_fmt[g]),
      .base   (base_q[g]),
      .size   (size_q),
      .o_valid(w_valid[g]),
      .o_ready(w_ready[g]),
      .o_data (w_data[g]),
      .fin    (w_fin[g])
    );
  end

  always_comb begin
    cnt_sum = {1'b0, seg_cnt[0]} + {1'b0, seg_cnt[1]};
    too_big = (seg_cnt[0] > CNT_W'(COMPAT_ONE_MAX)) ||
              (seg_cnt[1] > CNT_W'(COMPAT_ONE_MAX)) ||
              (cnt_sum > (CNT_W+1)'(COMPAT_SUM_MAX));
    words_total = WCNT_W'(1) + list_words(walk_fmt[0], seg_cnt[0])
                             + list_words(walk_fmt[1], seg_cnt[1]);
    hdr_word = '0;
    hdr_word[CNT_W-1:0]           = seg_cnt[0];
    hdr_word[2*CNT_W-1:CNT_W]     = seg_cnt[1];
    hdr_word[TYPE_LO+1:TYPE_LO]   = kind_q;
  end

  assign w_start[0] = (st_q == T_HDR) && out_ready;
  assign w_start[1] = (st_q == T_L0) && w_fin[0];
  assign w_ready[0] = (st_q == T_L0) && out_ready;
  assign w_ready[1] = (st_q == T_L1) && out_ready;

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    unique case (st_q)
      T_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_word;
      end
      T_L0: begin
        out_valid = w_valid[0];
        out_data  = w_data[0];
      end
      T_L1: begin
        out_valid = w_valid[1];
        out_data  = w_data[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= T_IDLE;
      kind_q    <= XF_INTERNAL;
      compat_q  <= 1'b0;
      size_q    <= '0;
      base_q[0] <= '0;
      base_q[1] <= '0;
      db_q      <= '0;
    end else begin
      unique case (st_q)
        T_IDLE: begin
          if (req_valid) begin
            kind_q    <= xfer_e'(req_type);
            compat_q  <= compat_en;
            size_q    <= req_size;
            base_q[0] <= req_first_addr;
            base_q[1] <= req_last_addr;
            st_q      <= T_COUNT;
          end
        end
        T_COUNT: begin
          if (counted) begin
            db_q <= words_total;
            st_q <= (compat_q && too_big) ? T_ERR : T_HDR;
          end
        end
        T_HDR:   if (out_ready) st_q <= T_L0;
        T_L0:    if (w_fin[0]) st_q <= T_L1;
        T_L1:    if (w_fin[1]) st_q <= T_DONE;
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == T_IDLE);
  assign done      = (st_q == T_DONE);
  assign err       = (st_q == T_ERR);
  assign doorbell  = db_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid); // R10

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid && !done ##1 req_ready); // R7

  AST_COMPAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && compat_q |-> seg_cnt[0] <= CNT_W'(COMPAT_ONE_MAX) &&
                              seg_cnt[1] <= CNT_W'(COMPAT_ONE_MAX)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready); // R8

  AST_DOORBELL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(doorbell)); // R8

endmodule

// File: tb/dmacmd_gen_test.sv
module dmacmd_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 40;
  localparam int SIZE_W = 19;
  localparam int DATA_W = 64;
  localparam int WCNT_W = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_type = '0;
  logic [ADDR_W-1:0] req_first_addr = '0;
  logic [ADDR_W-1:0] req_last_addr = '0;
  logic [SIZE_W-1:0] req_size = '0;
  logic              compat_en = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              done;
  logic              err;
  logic [WCNT_W-1:0] doorbell;

  int n_tests = 0;
  int n_fail = 0;

  logic [63:0] tmp [0:1][0:127];
  logic [63:0] exp_w [0:255];
  logic [63:0] got_w [0:255];
  int exp_n;
  int got_n;
  bit exp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmacmd_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_first_addr(req_first_addr), .req_last_addr(req_last_addr),
    .req_size(req_size), .compat_en(compat_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done), .err(err),
    .doorbell(doorbell)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Reference list builder from the requirements
  task automatic build_list(input int sel, input bit bus, input logic [39:0] base,
                            input int sz, output int segs, output int nw);
    logic [39:0] a;
    int r;
    a = base; r = sz; segs = 0; nw = 0;
    while (r > 0) begin
      if (!bus) begin
        int c;
        c = (r > 8191) ? 8191 : r;
        tmp[sel][nw] = (64'(a) << 13) | 64'(c);
        nw++; segs++;
        a = a + 40'(c);
        r = r - c;
      end else begin
        logic [63:0] lw;
        int hold;
        lw = '0;
        hold = nw;
        nw++;
        for (int k = 0; k < 4; k++) begin
          if (r > 0) begin
            int c;
            c = (r > 65535) ? 65535 : r;
            lw = lw | (64'(c) << (16 * k));
            tmp[sel][nw] = 64'(a);
            nw++; segs++;
            a = a + 40'(c);
            r = r - c;
          end
        end
        tmp[sel][hold] = lw;
      end
    end
  endtask

  task automatic build_expected(input int kind, input logic [39:0] fa, input logic [39:0] la,
                                input int sz, input bit compat);
    int s0, s1, n0, n1;
    bit b0, b1;
    b0 = (kind == 3);
    b1 = (kind != 0);
    build_list(0, b0, fa, sz, s0, n0);
    build_list(1, b1, la, sz, s1, n1);
    exp_err = compat && (s0 > 11 || s1 > 11 || s0 + s1 > 15);
    exp_w[0] = (64'(kind) << 14) | (64'(s1) << 7) | 64'(s0);
    exp_n = 1;
    for (int i = 0; i < n0; i++) begin exp_w[exp_n] = tmp[0][i]; exp_n++; end
    for (int i = 0; i < n1; i++) begin exp_w[exp_n] = tmp[1][i]; exp_n++; end
  endtask

  task automatic run_req(input int kind, input logic [39:0] fa, input logic [39:0] la,
                         input int sz, input bit compat, input string tag);
    bit seen_done, seen_err, pend, r;
    logic [63:0] pd;
    int db, bad_idx;
    build_expected(kind, fa, la, sz, compat);
    while (!req_ready) @(negedge clk);
    req_type = 2'(kind); req_first_addr = fa; req_last_addr = la;
    req_size = SIZE_W'(sz); compat_en = compat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen_done = 0; seen_err = 0; pend = 0; got_n = 0; db = 0; pd = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (done) begin seen_done = 1; db = int'(doorbell); break; end
      if (err) begin seen_err = 1; break; end
      if (pend)
        chk(out_valid && out_data == pd, "R10", "hold under back-pressure", longint'(out_data), longint'(pd));
      r = ($urandom % 4) != 0;
      out_ready = r;
      if (out_valid && r && got_n < 256) begin got_w[got_n] = out_data; got_n++; end
      pend = out_valid && !r;
      pd = out_data;
      @(negedge clk);
    end
    out_ready = 1'b0;
    if (exp_err) begin
      chk(seen_err, "R7", "reject pulse", longint'(seen_err), 1);
      chk(got_n == 0, "R7", "no words on reject", got_n, 0);
    end else begin
      chk(!seen_err && seen_done, tag, "done after last word", longint'(seen_done), 1);
      chk(got_n == exp_n, tag, "word count", got_n, exp_n);
      if (got_n > 0)
        chk(got_w[0] == exp_w[0], "R6", "header word", longint'(got_w[0]), longint'(exp_w[0]));
      bad_idx = -1;
      for (int i = 0; i < got_n && i < exp_n; i++)
        if (bad_idx < 0 && got_w[i] !== exp_w[i]) bad_idx = i;
      if (bad_idx >= 0)
        chk(0, tag, $sformatf("word %0d", bad_idx), longint'(got_w[bad_idx]), longint'(exp_w[bad_idx]));
      else
        chk(1, tag, "words", 0, 0);
      chk(db == exp_n, "R8", "doorbell", db, exp_n);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !out_valid && !done && !err, "R10", "reset state",
        longint'({req_ready, out_valid, done, err}), 8);

    run_req(0, 40'h00_1000_0000, 40'h00_2000_0000, 0, 0, "R9");
    run_req(3, 40'h12_0000_0000, 40'h34_0000_0000, 0, 1, "R9");
    run_req(0, 40'h00_0000_1000, 40'h00_0080_0000, 8191, 0, "R1");
    run_req(0, 40'h00_0000_1000, 40'h00_0080_0000, 8192, 0, "R1");
    run_req(1, 40'h00_0400_0000, 40'h80_0000_0000, 65535, 0, "R2");
    run_req(1, 40'h00_0400_0000, 40'h80_0000_0000, 65536, 0, "R2");
    run_req(2, 40'h00_0500_0010, 40'hC0_0000_0003, 20000, 0, "R4");
    run_req(3, 40'h01_0000_0000, 40'h02_0000_0000, 5*65535 + 10, 0, "R3");
    run_req(3, 40'hFF_FFFF_F000, 40'h00_0000_0000, 3*65535 + 1, 0, "R4");
    run_req(1, 40'h00_0000_0040, 40'h10_0000_0000, 131070, 0, "R5");
    run_req(0, 40'h00_0000_0000, 40'h00_1000_0000, 12*8191, 1, "R7");
    run_req(0, 40'h00_0000_0000, 40'h00_1000_0000, 12*8191, 0, "R5");
    run_req(0, 40'h00_0000_0000, 40'h00_1000_0000, 7*8191, 1, "R7");
    run_req(0, 40'h00_0000_0000, 40'h00_1000_0000, 8*8191, 1, "R7");
    run_req(3, 40'h00_0000_0000, 40'h00_1000_0000, 7*65535 + 1, 1, "R7");
    run_req(3, 40'h00_0000_0000, 40'h00_1000_0000, 7*65535, 1, "R7");

    for (int i = 0; i < 30; i++) begin
      int kind, sz;
      logic [39:0] fa, la;
      kind = int'($urandom % 4);
      sz = (($urandom % 4) == 0) ? int'($urandom % 20) : int'($urandom % 400000);
      fa = {8'($urandom), 32'($urandom)};
      la = {8'($urandom), 32'($urandom)};
      run_req(kind, fa, la, sz, bit'($urandom % 2), "R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule